// File: doc/BRIEF.md
# Clock-synthesizer configuration target on a two-wire serial bus

This block is a two-wire serial bus target (I2C style) that holds the configuration registers of a fractional-N clock synthesizer. It oversamples the bus lines with the system clock and removes short glitches with a digital filter. It pulls SDA low through an open-drain enable. It decodes a device address that is partly set by two strap pins. It keeps a 4-bit register pointer, and the upper nibble of that pointer is always 0xF. Hosts can write single bytes or pages, and can read with current-address, random and sequential reads.

The six frequency registers at 0xFA..0xFF exist twice, once in each of two banks. A control bit picks the bank that writes go to. Either a second control bit or the bank-select pin picks the bank whose values drive the outputs. A soft-reset bit holds every other register at its reset value until the host clears it.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: The target acknowledges only the 7-bit device address 1010_1_A1_A0, where {A1,A0} = strap_i[1:0]. On any other address it neither acknowledges nor drives SDA, and it stays idle until the next START.
- R2: In a write, the byte after the address is the register pointer. Every following data byte is stored at the pointer, the pointer then advances by one, and the target acknowledges each byte.
- R3: Only bits [3:0] of the pointer byte are kept, and the upper nibble always reads as 0xF. An auto-increment past 0xFF wraps to 0xF0.
- R4: A read that starts directly with the read address returns the register one past the last one accessed.
- R5: A write that carries only a pointer, followed by a repeated START and a read address, returns the register at that pointer.
- R6: In a read, a host ACK makes the target send the next register. After a host NACK the target releases SDA and stays idle.
- R7: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Data is sampled on the rising edge of SCL, and the target changes its SDA drive only while SCL is low.
- R8: Reset values are FF=00, FE=00, FD=00, FC=20, FB=77, FA=61, F9=05, F8=00, F7=00, F6=00, F5=01. The implemented-bit masks are FF:03, FC/FB:7F, F9/F8/F6:0F, F7:FB, F5:03, and full bytes for FA/FD/FE. Unimplemented bits read as zero.
- R9: The registers FA..FF are held in two banks.
  - Bit 6 of F7 picks the bank that writes go to, and reads of FA..FF return that same bank.
  - The active bank (bank_o) is fsel_i when bit 5 of F7 is 1, and bit 7 of F7 otherwise.
  - fset_o carries the active bank as {FF,FE,FD,FC,FB,FA}, and ctl_o carries {F7,F6,F5}.
- R10: While bit 0 of F7 is 1, every other register, including the other bits of F7 and both banks, is held at its reset value and writes to them are lost. Only a host write of 0 to that bit or the reset pin clears it.
- R11: Pointers F0..F4 are acknowledged, writes to them are dropped, and reads from them return 0x00.
- R12: A pulse on SCL or SDA that lasts fewer than FILT_CYC system clocks has no effect on the bus state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| strap_i | input | 2 | Address straps {A1,A0} |
| fsel_i | input | 1 | Bank-select pin |
| bank_o | output | 1 | Active bank |
| fset_o | output | 48 | Active-bank frequency registers {FF,FE,FD,FC,FB,FA} |
| ctl_o | output | 24 | Control registers {F7,F6,F5} |

## Verification
The bench builds the block with FILT_CYC = 4 and straps set to 2'b10, so the device address byte is 0xAC for writes and 0xAD for reads. A bit period of 64 system clocks keeps every bus edge well clear of the filter and synchronizer lag. The short filter lets a 2-cycle pulse, placed on SDA while SCL is high and on SCL while SCL is low, show that a false STOP and a false extra clock are both rejected. The pointer wrap and the test-register gap at F0..F4 are both crossed by a single page write and by a single sequential read.

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target #(
  parameter int FILT_CYC = 25
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [1:0]  strap_i,
  input  logic        fsel_i,
  output logic        bank_o,
  output logic [47:0] fset_o,
  output logic [23:0] ctl_o
);
  localparam int FCW = $clog2(FILT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} ph_t;
  typedef enum logic [1:0] {K_ADR, K_PTR, K_DAT} kd_t;

  logic [1:0] ln_i, ln_f, ln_d;
  assign ln_i = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    logic [1:0]     sy;
    logic [FCW-1:0] c;
    logic           f, d;
    always_ff @(posedge clk) begin
      if (rst) begin
        sy <= 2'b11; c <= '0; f <= 1'b1; d <= 1'b1;
      end else begin
        sy <= {sy[0], ln_i[g]};
        d  <= f;
        if (sy[1] == f) c <= '0;
        else if (c == FCW'(FILT_CYC - 1)) begin
          f <= sy[1];
          c <= '0;
        end else c <= c + 1'b1;
      end
    end
    assign ln_f[g] = f;
    assign ln_d[g] = d;
  end

  wire scl_f    = ln_f[0];
  wire sda_f    = ln_f[1];
  wire scl_rise = ln_f[0] & ~ln_d[0];
  wire scl_fall = ~ln_f[0] & ln_d[0];
  wire bus_hi   = ln_f[0] & ln_d[0];
  wire start    = bus_hi & ~ln_f[1] & ln_d[1];
  wire stop     = bus_hi & ln_f[1] & ~ln_d[1];

  ph_t        ph;
  kd_t        kd;
  logic [3:0] cnt, ptr;
  logic [7:0] sh, rd_dat;
  logic       rw, oe, more;

  logic [7:0] bk [2][6];
  logic [7:0] r5, r6, r7, r8, r9;
  logic [1:0] fsel_s;
  logic       bank_q;

  wire       srst    = r7[0];
  wire       wbank   = r7[6];
  wire [2:0] bidx    = 3'(ptr - 4'hA);
  wire       dev_hit = sh[7:1] == {4'b1010, 1'b1, strap_i};
  wire       wr_en   = (ph == S_RX) && (kd == K_DAT) && scl_fall && (cnt == 4'd8);

  function automatic logic [7:0] msk(input logic [3:0] a);
    case (a)
      4'hF, 4'h5:             msk = 8'h03;
      4'hC, 4'hB:             msk = 8'h7F;
      4'h9, 4'h8, 4'h6:       msk = 8'h0F;
      4'h7:                   msk = 8'hFB;
      4'hA, 4'hD, 4'hE:       msk = 8'hFF;
      default:                msk = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rstv(input logic [3:0] a);
    case (a)
      4'hC:    rstv = 8'h20;
      4'hB:    rstv = 8'h77;
      4'hA:    rstv = 8'h61;
      4'h9:    rstv = 8'h05;
      4'h5:    rstv = 8'h01;
      default: rstv = 8'h00;
    endcase
  endfunction

  always_comb begin
    case (ptr)
      4'h5:    rd_dat = r5;
      4'h6:    rd_dat = r6;
      4'h7:    rd_dat = r7;
      4'h8:    rd_dat = r8;
      4'h9:    rd_dat = r9;
      4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF: rd_dat = bk[wbank][bidx];
      default: rd_dat = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= S_IDLE; kd <= K_ADR; cnt <= '0; sh <= '0; ptr <= '0;
      rw <= 1'b0; oe <= 1'b0; more <= 1'b0;
    end else if (start) begin
      ph <= S_RX; kd <= K_ADR; cnt <= '0; oe <= 1'b0;
    end else if (stop) begin
      ph <= S_IDLE; oe <= 1'b0;
    end else begin
      case (ph)
        S_RX:
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_f};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            case (kd)
              K_ADR: if (dev_hit) begin
                       rw <= sh[0]; oe <= 1'b1; ph <= S_ACK;
                     end else ph <= S_IDLE;
              K_PTR: begin ptr <= sh[3:0]; oe <= 1'b1; ph <= S_ACK; end
              default: begin ptr <= ptr + 1'b1; oe <= 1'b1; ph <= S_ACK; end
            endcase
          end
        S_ACK:
          if (scl_fall) begin
            if (kd == K_ADR && rw) begin
              sh <= rd_dat; oe <= ~rd_dat[7]; ph <= S_TX;
            end else begin
              oe <= 1'b0; ph <= S_RX;
              kd <= (kd == K_ADR) ? K_PTR : K_DAT;
            end
          end
        S_TX:
          if (scl_rise) cnt <= cnt + 1'b1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe <= 1'b0; ptr <= ptr + 1'b1; cnt <= '0; ph <= S_RACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; oe <= ~sh[6];
            end
          end
        S_RACK:
          if (scl_rise) more <= ~sda_f;
          else if (scl_fall) begin
            if (more) begin
              sh <= rd_dat; oe <= ~rd_dat[7]; ph <= S_TX;
            end else ph <= S_IDLE;
          end
        default: ph <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 6; i++) bk[b][i] <= rstv(4'(i + 10));
      r5 <= rstv(4'h5); r6 <= 8'h00; r7 <= 8'h00; r8 <= 8'h00; r9 <= rstv(4'h9);
    end else begin
      if (wr_en) begin
        case (ptr)
          4'h5: r5 <= sh & msk(ptr);
          4'h6: r6 <= sh & msk(ptr);
          4'h7: r7 <= sh & msk(ptr);
          4'h8: r8 <= sh & msk(ptr);
          4'h9: r9 <= sh & msk(ptr);
          4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF: bk[wbank][bidx] <= sh & msk(ptr);
          default: ;
        endcase
      end
      if (srst) begin
        for (int b = 0; b < 2; b++)
          for (int i = 0; i < 6; i++) bk[b][i] <= rstv(4'(i + 10));
        r5 <= rstv(4'h5); r6 <= 8'h00; r8 <= 8'h00; r9 <= rstv(4'h9);
        r7[7:1] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_s <= 2'b00; bank_q <= 1'b0;
    end else begin
      fsel_s <= {fsel_s[0], fsel_i};
      bank_q <= r7[5] ? fsel_s[1] : r7[7];
    end
  end

  assign sda_oe_o = oe;
  assign bank_o   = bank_q;
  assign fset_o   = {bk[bank_q][5], bk[bank_q][4], bk[bank_q][3],
                     bk[bank_q][2], bk[bank_q][1], bk[bank_q][0]};
  assign ctl_o    = {r7, r6, r5};

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    ph == S_IDLE |-> !oe);
  a_r7_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe) |-> !scl_f);
  a_r6_release_host_ack: assert property (@(posedge clk) disable iff (rst)
    ph == S_RACK |-> !oe);
  a_r10_soft_reset_hold: assert property (@(posedge clk) disable iff (rst)
    srst |=> (r6 == 8'h00 && r5 == 8'h01 && bk[0][2] == 8'h20 && bk[1][0] == 8'h61 && r7[7:1] == 7'd0));
  a_r9_bank_from_reg: assert property (@(posedge clk) disable iff (rst)
    !r7[5] |=> bank_q == $past(r7[7]));
endmodule

// File: tb/sim_clkcfg_i2c_target.sv
`timescale 1ns/1ps
module sim_clkcfg_i2c_target;
  localparam int Q = 16;
  localparam logic [7:0] DEVW = 8'hAC;
  localparam logic [7:0] DEVR = 8'hAD;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic scl = 1'b1, hl = 1'b0, fsel = 1'b0;
  logic [1:0] strap = 2'b10;
  wire sda_oe, bank;
  wire [47:0] fset;
  wire [23:0] ctl;
  wire sda_line = ~(hl | sda_oe);

  clkcfg_i2c_target #(.FILT_CYC(4)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .fsel_i(fsel), .bank_o(bank), .fset_o(fset), .ctl_o(ctl));

  int nchk = 0, nerr = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rd_val;
  event rd_ev;

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) begin
      nchk++; nerr++;
      $display("FAIL read: actual %0h expected none", rd_val);
    end else begin
      string t;
      logic [7:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      chk(t, rd_val, e);
    end
  end

  task automatic sstart;
    hl = 1'b0; w(Q); scl = 1'b1; w(Q); hl = 1'b1; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic sstop;
    hl = 1'b1; w(Q); scl = 1'b1; w(Q); hl = 1'b0; w(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      hl = ~b[i];
      if (glitch && i == 2) begin
        w(5); scl = 1'b1; w(2); scl = 1'b0; w(Q - 7);
      end else w(Q);
      scl = 1'b1; w(Q);
      if (glitch && i == 4) begin
        hl = ~hl; w(2); hl = ~hl; w(Q - 2);
      end else w(Q);
      scl = 1'b0; w(Q);
    end
    hl = 1'b0; w(Q); scl = 1'b1; w(Q); ack = ~sda_line; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic rbyte(input bit ack);
    logic [7:0] b;
    hl = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1'b1; w(Q); b[i] = sda_line; w(Q); scl = 1'b0; w(Q);
    end
    rd_val = b;
    ->rd_ev;
    hl = ack; w(Q); scl = 1'b1; w(2 * Q); scl = 1'b0; w(Q); hl = 1'b0;
  endtask

  task automatic wr_regs(input logic [7:0] p, input logic [31:0] d, input int n, input string tag);
    bit a;
    sstart;
    wbyte(DEVW, 1'b0, a); chk({tag, " addr ack"}, a, 1);
    wbyte(p, 1'b0, a);    chk({tag, " ptr ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(d[8*(n-1-i) +: 8], 1'b0, a); chk({tag, " data ack"}, a, 1);
    end
    sstop; w(10);
  endtask

  task automatic rd_regs(input logic [7:0] p, input logic [39:0] e, input int n, input string tag);
    bit a;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e[8*(n-1-i) +: 8]); tag_q.push_back(tag);
    end
    sstart;
    wbyte(DEVW, 1'b0, a); chk({tag, " R5 addr ack"}, a, 1);
    wbyte(p, 1'b0, a);    chk({tag, " R5 ptr ack"}, a, 1);
    sstart;
    wbyte(DEVR, 1'b0, a); chk({tag, " R7 repeated start ack"}, a, 1);
    for (int i = 0; i < n; i++) rbyte(i != n - 1);
    sstop; w(10);
  endtask

  task automatic cur_rd(input logic [7:0] e, input string tag);
    bit a;
    exp_q.push_back(e); tag_q.push_back(tag);
    sstart;
    wbyte(DEVR, 1'b0, a); chk({tag, " read addr ack"}, a, 1);
    rbyte(1'b0);
    sstop; w(10);
  endtask

  initial begin
    bit a;
    w(5); rst = 1'b0; w(5);
    chk("R8 reset fset", fset, 48'h000000207761);
    chk("R8 reset ctl", ctl, 24'h000001);
    chk("R8 reset bank", bank, 0);
    chk("R8 reset sda", sda_oe, 0);

    sstart; wbyte(8'hA8, 1'b0, a);
    chk("R1 foreign address nack", a, 0);
    wbyte(8'h00, 1'b0, a);
    chk("R1 stays silent", a, 0);
    sstop; w(10);

    rd_regs(8'hF9, 40'h05, 1, "R5 random read F9");
    cur_rd(8'h61, "R4 current read FA");

    wr_regs(8'h0D, 32'h11223344, 4, "R2 page write wraps");
    cur_rd(8'h00, "R11 read test reg F1");
    rd_regs(8'hFD, 40'h1122030000, 5, "R3 R6 sequential wrap");
    chk("R2 fset after page write", fset, 48'h032211207761);

    wr_regs(8'hF6, 32'hFF, 1, "R8 mask F6");
    chk("R8 ctl masked", ctl, 24'h000F01);
    wr_regs(8'hF2, 32'hA5, 1, "R11 write test reg");
    rd_regs(8'hF2, 40'h00, 1, "R11 test reg reads zero");

    wr_regs(8'hF7, 32'h40, 1, "R9 write bank 1");
    wr_regs(8'hFA, 32'hAB, 1, "R9 write FA bank 1");
    rd_regs(8'hFA, 40'hAB, 1, "R9 read follows write bank");
    chk("R9 active bank untouched", fset, 48'h032211207761);
    chk("R9 bank 0", bank, 0);
    wr_regs(8'hF7, 32'hC0, 1, "R9 access bank 1");
    chk("R9 bank reg select", bank, 1);
    chk("R9 fset bank 1", fset, 48'h0000002077AB);
    wr_regs(8'hF7, 32'h20, 1, "R9 pin control");
    fsel = 1'b0; w(10);
    chk("R9 pin low bank", bank, 0);
    chk("R9 pin low fset", fset, 48'h032211207761);
    fsel = 1'b1; w(10);
    chk("R9 pin high bank", bank, 1);
    chk("R9 pin high fset", fset, 48'h0000002077AB);
    rd_regs(8'hFA, 40'h61, 1, "R9 read write bank 0");

    wr_regs(8'hF7, 32'h01, 1, "R10 set soft reset");
    chk("R10 ctl held", ctl, 24'h010001);
    chk("R10 fset reset", fset, 48'h000000207761);
    chk("R10 bank reset", bank, 0);
    wr_regs(8'hF6, 32'h05, 1, "R10 write during reset");
    rd_regs(8'hF6, 40'h00, 1, "R10 write lost");
    wr_regs(8'hF7, 32'h00, 1, "R10 clear soft reset");
    wr_regs(8'hF6, 32'h05, 1, "R10 write after clear");
    chk("R10 ctl after clear", ctl, 24'h000501);
    wr_regs(8'hF7, 32'h40, 1, "R10 select bank 1");
    rd_regs(8'hFA, 40'h61, 1, "R10 bank 1 was reset");

    sstart;
    wbyte(DEVW, 1'b0, a);
    wbyte(8'hF8, 1'b0, a);
    wbyte(8'h0A, 1'b1, a);
    chk("R12 glitched byte ack", a, 1);
    sstop; w(10);
    rd_regs(8'hF8, 40'h0A, 1, "R12 glitches ignored");

    exp_q.push_back(8'h01); tag_q.push_back("R6 read F5");
    sstart;
    wbyte(DEVW, 1'b0, a);
    wbyte(8'hF5, 1'b0, a);
    sstart;
    wbyte(DEVR, 1'b0, a);
    rbyte(1'b0);
    w(4);
    chk("R6 released after nack", sda_oe, 0);
    sstop; w(20);

    chk("R6 all reads seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule